// File: doc/BRIEF.md
# Glitch-free programmable clock post-divider

This block takes one fast input clock that runs at the oscillator rate and derives three clock-enable strobes from it. The core strobe fires once every N input cycles, where N is a programmable post-divide value. The peripheral strobe fires on every second core strobe, and this ratio cannot be changed. The memory strobe fires on every M-th core strobe, where M is programmable and defaults to 2.

New ratios are presented on two select inputs. They are captured only in a cycle where the update-enable input is high. A captured pair stays pending until the next frame boundary, which is a core strobe that also ends a peripheral period and a memory period. At that boundary both ratios switch together. No strobe interval is ever cut short, and the strobes keep running with no bypass step.

A settled flag falls when an update is captured. It rises again at the end of the first full core period at the new ratio. Reset restores core divide-by-2 and memory divide-by-2, and it drops any pending update.

Top module: `clk_postdiv_gen`

## Requirements
- R1: After reset the core strobe period is 2 input cycles, the peripheral period is 4 and the memory period is 4, and `ratio_settled` is 1.
- R2: While `div_en` is 0, changes on `core_sel` and `mem_sel` leave every strobe period and `ratio_settled` unchanged.
- R3: After an update, the core strobe period follows `core_sel`: 0 gives 1 input cycle, 1 gives 2, 2 gives 4 and 3 gives 8.
- R4: The peripheral strobe always fires on every second core strobe, so its period is twice the core period.
- R5: After an update, the memory strobe period in core periods follows `mem_sel`: 0 gives 2, 1 gives 3, 2 gives 4, and 3 is an unsupported code treated as the nearest legal value, 4.
- R6: `ratio_settled` is 0 in the cycle after a `div_en` capture. It rises on a core strobe, no more than 14 core strobes after the capture.
- R7: During a ratio change, every interval between core strobes equals either the old period or the new period.
- R8: A reset applied while an update is pending discards the update and restores the R1 state.
- R9: The peripheral and memory strobes fire only in cycles where the core strobe fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock at the oscillator rate |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| div_en | input | 1 | Update enable; the select inputs are captured in cycles where it is 1 |
| core_sel | input | 2 | Core post-divide select |
| mem_sel | input | 2 | Memory divisor select, counted in core periods |
| core_tick | output | 1 | Core clock-enable strobe |
| per_tick | output | 1 | Peripheral clock-enable strobe, at half the core rate |
| mem_tick | output | 1 | Memory clock-enable strobe |
| ratio_settled | output | 1 | High when no change is pending and the new ratio has run one full period |

## Verification
The core divider is tested at all four select codes. The memory divider is tested at all four of its codes, including the unsupported one, so that a mapping error or a swapped code shows up as a wrong measured period. Changes are made downward, from divide-by-2 to divide-by-1, and upward, from divide-by-1 to divide-by-8. The bench records every core interval across each change, which tells a clean switch at a frame boundary apart from one that truncates the old period. The remaining tests move the select inputs with the enable low, and assert reset while an update is pending. Each of these would show if a value were latched when it should not be.

// File: rtl/clk_postdiv_gen.sv
module clk_postdiv_gen #(
  parameter int SEL_W  = 2,
  parameter int CORE_W = 4,
  parameter int MEM_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_en,
  input  logic [SEL_W-1:0] core_sel,
  input  logic [SEL_W-1:0] mem_sel,
  output logic             core_tick,
  output logic             per_tick,
  output logic             mem_tick,
  output logic             ratio_settled
);

  localparam logic [SEL_W-1:0] CORE_RST = SEL_W'(1);
  localparam logic [MEM_W-1:0] MEM_RST  = MEM_W'(2);

  function automatic logic [MEM_W-1:0] mem_map(input logic [SEL_W-1:0] s);
    case (s)
      2'd0:    mem_map = MEM_W'(2);
      2'd1:    mem_map = MEM_W'(3);
      default: mem_map = MEM_W'(4);
    endcase
  endfunction

  logic [SEL_W-1:0]  cur_c, pend_c;
  logic [MEM_W-1:0]  cur_m, pend_m;
  logic [CORE_W-1:0] cc;
  logic [MEM_W-1:0]  mc;
  logic              pc, pend, armed, settled_q;

  wire [CORE_W-1:0] core_div = CORE_W'(1) << cur_c;
  wire              frame_end = per_tick & mem_tick;

  assign core_tick     = (cc == core_div - CORE_W'(1));
  assign per_tick      = core_tick & pc;
  assign mem_tick      = core_tick & (mc == cur_m - MEM_W'(1));
  assign ratio_settled = settled_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_c     <= CORE_RST;
      cur_m     <= MEM_RST;
      pend_c    <= CORE_RST;
      pend_m    <= MEM_RST;
      cc        <= '0;
      mc        <= '0;
      pc        <= 1'b0;
      pend      <= 1'b0;
      armed     <= 1'b0;
      settled_q <= 1'b1;
    end else begin
      cc <= core_tick ? '0 : cc + CORE_W'(1);
      if (core_tick) begin
        pc <= ~pc;
        mc <= mem_tick ? '0 : mc + MEM_W'(1);
      end

      if (frame_end && pend) begin
        cur_c <= pend_c;
        cur_m <= pend_m;
        armed <= 1'b1;
      end else if (armed && core_tick && !pend) begin
        armed <= 1'b0;
      end

      if (div_en)
        settled_q <= 1'b0;
      else if (armed && core_tick && !pend)
        settled_q <= 1'b1;

      if (div_en) begin
        pend   <= 1'b1;
        pend_c <= core_sel;
        pend_m <= mem_map(mem_sel);
      end else if (frame_end) begin
        pend <= 1'b0;
      end
    end
  end

endmodule

module clk_postdiv_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic div_en,
  input logic core_tick,
  input logic per_tick,
  input logic mem_tick,
  input logic ratio_settled
);

  p_per_in_core_r9: assert property (@(posedge clk) disable iff (!rst_n)
    per_tick |-> core_tick);

  p_mem_in_core_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_tick |-> core_tick);

  p_per_spaced_r4: assert property (@(posedge clk) disable iff (!rst_n)
    per_tick |=> !per_tick);

  p_settle_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    div_en |=> !ratio_settled);

  p_settle_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ratio_settled && !div_en && rst_n) |=> (ratio_settled ? $past(core_tick) : 1'b1));

  p_reset_settled_r1: assert property (@(posedge clk)
    !rst_n |=> ratio_settled);

endmodule

bind clk_postdiv_gen clk_postdiv_gen_chk u_chk (.*);

// File: tb/clk_postdiv_gen_bench.sv
module clk_postdiv_gen_bench;
  logic clk = 1'b0, rst_n = 1'b0, div_en = 1'b0;
  logic [1:0] core_sel = 2'd1, mem_sel = 2'd0;
  logic core_tick, per_tick, mem_tick, ratio_settled;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  clk_postdiv_gen u_clk_postdiv_gen (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit sel_tick(input int w);
    return w == 0 ? core_tick : (w == 1 ? per_tick : mem_tick);
  endfunction

  task automatic period(input int w, output int p);
    do @(negedge clk); while (!sel_tick(w));
    p = 0;
    do begin @(negedge clk); p++; end while (!sel_tick(w));
  endtask

  task automatic check_periods(input string req, input int cp, input int mp);
    int p;
    period(0, p); chk(p == cp, req, p, cp);
    period(1, p); chk(p == 2 * cp, {req, "/R4"}, p, 2 * cp);
    period(2, p); chk(p == mp * cp, req, p, mp * cp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // drives an update and tracks R6/R7 across it
  task automatic update(input logic [1:0] cs, input logic [1:0] ms, input int oldp, input int newp);
    int ticks = 0, gap = 0, bad = 0;
    bit seen = 0;
    @(negedge clk);
    core_sel = cs; mem_sel = ms; div_en = 1'b1;
    @(negedge clk);
    div_en = 1'b0;
    chk(ratio_settled == 1'b0, "R6 drop", ratio_settled, 0);
    while (!ratio_settled && ticks < 40) begin
      if (core_tick) begin
        if (seen && gap != oldp && gap != newp) bad++;
        seen = 1; gap = 0; ticks++;
      end
      @(negedge clk); gap++;
    end
    chk(ticks <= 14, "R6 settle", ticks, 14);
    chk(bad == 0, "R7 intervals", bad, 0);
  endtask

  task automatic t_reset();
    do_reset();
    chk(ratio_settled == 1'b1, "R1 settled", ratio_settled, 1);
    check_periods("R1", 2, 2);
  endtask

  task automatic t_ignore();
    int p;
    core_sel = 2'd3; mem_sel = 2'd2;
    repeat (5) @(negedge clk);
    chk(ratio_settled == 1'b1, "R2 settled", ratio_settled, 1);
    check_periods("R2", 2, 2);
  endtask

  task automatic t_down();
    update(2'd0, 2'd0, 2, 1);
    check_periods("R3 div1", 1, 2);
  endtask

  task automatic t_up();
    update(2'd3, 2'd1, 1, 8);
    check_periods("R3 div8/R5 m3", 8, 3);
  endtask

  task automatic t_mem_codes();
    update(2'd2, 2'd2, 8, 4);
    check_periods("R5 m4", 4, 4);
    update(2'd2, 2'd3, 4, 4);
    check_periods("R5 code3", 4, 4);
    update(2'd1, 2'd0, 4, 2);
    check_periods("R5 m2", 2, 2);
  endtask

  task automatic t_reset_pending();
    @(negedge clk);
    core_sel = 2'd3; mem_sel = 2'd1; div_en = 1'b1;
    @(negedge clk);
    div_en = 1'b0;
    do_reset();
    chk(ratio_settled == 1'b1, "R8 settled", ratio_settled, 1);
    check_periods("R8", 2, 2);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_ignore();
        t_down();
        t_up();
        t_mem_codes();
        t_reset_pending();
      end
      begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule